// File: doc/BRIEF.md
# Shared-Counter 64-Bit Ones Counter

This block reports how many bits are set in a 64-bit data word. Its 7-bit result covers every value from 0 to 64. It holds a single combinational counter that is 32 bits wide, and it reuses that counter over two clock cycles instead of building a full-width adder tree. On the first cycle the counter takes the low half of the word straight from the input. The block keeps that partial count and, on the same edge, keeps a copy of the high half. On the second cycle the counter takes the stored high half, and the block adds the two partial counts into the output register.

The two-cycle phase runs without stopping, so a new input word needs no start strobe. Because both halves come from one clock edge, every value the output register takes is the count of a single word. The output changes only when a full sum is written and holds that value between writes. All registers change on the rising clock edge. An active-low reset asserts at once and is released through a synchronizer.

Top module: `popc64_tmux`

## Requirements
- R1: `cnt_o` equals the number of set bits in `word_i`, over the full range 0 to 64.
- R2: Once `word_i` has been held steady, `cnt_o` shows its count no later than the third rising edge of `clk`, which is inside the limit of four edges.
- R3: The all-zero word gives 0 and the all-ones word gives 64.
- R4: `cnt_o` changes only on the edge that writes a complete two-half sum. It keeps its last value on all other edges, so a single-half count never shows on the output.
- R5: One 32-bit counter serves both halves. The phase alternates on every rising edge and never stops, so a new word is picked up from any phase without a start signal.
- R6: When `rst_n` is low, `cnt_o` reads 0 at once, without waiting for a clock edge. The release of reset takes effect two rising edges later.
- R7: Both halves added into one sum come from the word sampled on a single edge. When the input alternates every cycle between two words, `cnt_o` only ever shows the count of one of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register changes on its rising edge |
| rst_n | input | 1 | Active-low reset, asserts asynchronously and releases synchronously |
| word_i | input | 64 | Data word whose set bits are counted |
| cnt_o | output | 7 | Count of set bits in the most recently completed word |

## Verification
The hardest case to reach from the ports is an input that changes between the two phases of one count. A design that read the high half live would then add halves from two different words and show a count belonging to neither. To reach that case, the bench alternates the input every cycle between two words with distinct counts. The words are chosen so that both ways of mixing their halves give values that match neither word's count. The bench then checks at every cycle that the output shows only one of the two legal counts. A mid-run reset and steady held words at each phase alignment cover the rest.

// File: rtl/popc_pkg.sv
package popc_pkg;
  localparam int unsigned POPC_WORD_W = 64;
  localparam int unsigned POPC_SYNC_STAGES = 2;
endpackage

// File: rtl/popc_rst_sync.sv
module popc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) chain_q <= '0;
    else              chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/popc_half_unit.sv
module popc_half_unit #(
  parameter int unsigned IN_W  = 32,
  localparam int unsigned OUT_W = $clog2(IN_W + 1)
) (
  input  logic [IN_W-1:0]  bits_i,
  output logic [OUT_W-1:0] ones_o
);
  always_comb begin
    ones_o = '0;
    for (int k = 0; k < int'(IN_W); k++) begin
      ones_o = ones_o + OUT_W'(bits_i[k]);
    end
  end
endmodule

// File: rtl/popc_accum.sv
module popc_accum #(
  parameter int unsigned WORD_W = 64,
  localparam int unsigned HALF_W = WORD_W / 2,
  localparam int unsigned HCNT_W = $clog2(HALF_W + 1),
  localparam int unsigned CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_i,
  output logic [HALF_W-1:0] unit_in_o,
  input  logic [HCNT_W-1:0] unit_cnt_i,
  output logic [CNT_W-1:0]  cnt_o
);
  logic              phase_q, phase_d;
  logic [HCNT_W-1:0] lo_q, lo_d;
  logic [HALF_W-1:0] hi_q, hi_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cap_en, sum_en;

  // next state
  always_comb begin
    phase_d   = ~phase_q;
    cap_en    = ~phase_q;
    sum_en    = phase_q;
    lo_d      = unit_cnt_i;
    hi_d      = word_i[WORD_W-1:HALF_W];
    cnt_d     = CNT_W'(lo_q) + CNT_W'(unit_cnt_i);
    unit_in_o = phase_q ? hi_q : word_i[HALF_W-1:0];
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      lo_q    <= '0;
      hi_q    <= '0;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (cap_en) begin
        lo_q <= lo_d;
        hi_q <= hi_d;
      end
      if (sum_en) cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  AST_PHASE_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q |=> !phase_q); // R5
  AST_PHASE_RESUMES: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_q |=> phase_q); // R5
  AST_HOLD_BETWEEN_SUMS: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_q |=> $stable(cnt_o)); // R4
  AST_SUM_COVERS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q |=> (cnt_o >= CNT_W'($past(lo_q)))); // R1
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o <= CNT_W'(WORD_W)); // R1
  AST_HALF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    unit_cnt_i <= HCNT_W'(HALF_W)); // R5
  AST_HIGH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q |=> $stable(hi_q)); // R7
endmodule

// File: rtl/popc64_tmux.sv
module popc64_tmux
  import popc_pkg::*;
#(
  parameter int unsigned WORD_W = POPC_WORD_W,
  parameter int unsigned SYNC_STAGES = POPC_SYNC_STAGES,
  localparam int unsigned HALF_W = WORD_W / 2,
  localparam int unsigned HCNT_W = $clog2(HALF_W + 1),
  localparam int unsigned CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_i,
  output logic [CNT_W-1:0]  cnt_o
);
  logic              rst_core_n;
  logic [HALF_W-1:0] unit_in;
  logic [HCNT_W-1:0] unit_cnt;

  popc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk         (clk),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_core_n)
  );

  popc_half_unit #(.IN_W(HALF_W)) u_half_unit (
    .bits_i (unit_in),
    .ones_o (unit_cnt)
  );

  popc_accum #(.WORD_W(WORD_W)) u_accum (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .word_i     (word_i),
    .unit_in_o  (unit_in),
    .unit_cnt_i (unit_cnt),
    .cnt_o      (cnt_o)
  );

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |-> (cnt_o == '0)); // R6
endmodule

// File: tb/popc64_tmux_bench.sv
module popc64_tmux_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;
  localparam logic [63:0] VEC_W [NVEC] = '{
    64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001,
    64'h8000_0000_0000_0000, 64'h0000_0000_FFFF_FFFF, 64'hFFFF_FFFF_0000_0000,
    64'h5555_5555_5555_5555, 64'hF0F0_0000_0000_000F, 64'h0000_0001_8000_0000,
    64'h7FFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF };
  localparam logic [6:0] VEC_C [NVEC] = '{
    7'd0, 7'd64, 7'd1, 7'd1, 7'd32, 7'd32, 7'd32, 7'd12, 7'd2, 7'd63, 7'd32 };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] word_i = '0;
  logic [6:0]  cnt_o;
  int          n_tests = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  popc64_tmux u_popc64_tmux (.clk(clk), .rst_n(rst_n), .word_i(word_i), .cnt_o(cnt_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [6:0] ref_ones(input logic [63:0] w);
    logic [6:0] s = '0;
    for (int k = 0; k < 64; k++) if (w[k]) s = s + 7'd1;
    return s;
  endfunction

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: cnt_o=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    // R6: reset state
    wait_neg(2);
    check("R6 reset value", cnt_o, 7'd0);
    rst_n = 1'b1;
    wait_neg(4);

    // R1 R3 table walk, checked at the fourth falling edge
    for (int i = 0; i < NVEC; i++) begin
      word_i = VEC_W[i];
      wait_neg(4);
      check((i < 2) ? "R3 extreme word" : "R1 table word", cnt_o, VEC_C[i]);
    end

    // R2: three edges suffice from both phase alignments
    for (int a = 0; a < 2; a++) begin
      word_i = '0;
      wait_neg(4 + a);
      word_i = 64'h0000_00FF_0000_0F00;
      wait_neg(3);
      check("R2 latency", cnt_o, 7'd12);
    end

    // R4 R7: input alternates every cycle; only the two words' counts may show
    word_i = 64'h0000_0000_0000_0007;
    wait_neg(4);
    for (int c = 0; c < 20; c++) begin
      word_i = c[0] ? 64'h0000_0000_0000_0007 : 64'h0000_FFFF_0000_0000;
      @(negedge clk);
      n_tests++;
      if (cnt_o !== 7'd3 && cnt_o !== 7'd16) begin
        n_fail++;
        $display("FAIL R7 mixed halves: cnt_o=%0d expected=3 or 16", cnt_o);
      end
    end

    // R4: after a change the output is old or new, never a half count
    word_i = 64'hFFFF_FFFF_FFFF_FFFF;
    wait_neg(4);
    word_i = 64'h0000_0000_0000_0003;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      n_tests++;
      if (cnt_o !== 7'd64 && cnt_o !== 7'd2) begin
        n_fail++;
        $display("FAIL R4 partial count: cnt_o=%0d expected=64 or 2", cnt_o);
      end
    end
    check("R4 settled", cnt_o, 7'd2);

    // R5: random run-length words, counted from whatever phase is current
    for (int t = 0; t < 200; t++) begin
      logic [63:0] w;
      logic        b;
      int          pos;
      w = '0;
      b = 1'($urandom);
      pos = 0;
      while (pos < 64) begin
        int run;
        run = (t % 2 == 1) ? int'($urandom % 8) + 1 : int'($urandom % 64) + 1;
        for (int k = 0; k < run && pos < 64; k++) begin
          w[pos] = b;
          pos++;
        end
        b = ~b;
      end
      word_i = w;
      wait_neg(4 + (t % 2));
      check("R5 random runs", cnt_o, ref_ones(w));
    end

    // R6: asynchronous clear mid-run, then recovery
    word_i = 64'h00FF_00FF_00FF_00FF;
    wait_neg(4);
    #2 rst_n = 1'b0;
    #1 check("R6 async clear", cnt_o, 7'd0);
    @(negedge clk);
    rst_n = 1'b1;
    wait_neg(6);
    check("R6 recovery", cnt_o, 7'd32);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule